// File: doc/BRIEF.md
# DMA Channel Group Run Control

This block decides, for a group of DMA channels, which channels may move data at any given moment. It keeps three pieces of global state: a group-wide run enable, a sticky flag recording a non-maskable interrupt (NMI), and a sticky flag recording an address fault reported by any channel. It combines these with each channel's own enable and finish inputs to produce one permit line per channel. It also raises a one-cycle stop pulse whenever a live channel loses its permit.

Software reaches the state through a small control-word port. The port reads the word combinationally and writes it on a strobe. The two sticky flags follow a handshake: a flag can be cleared only by writing 0 to it after a read has seen it at 1. Each channel reports whether it is in the middle of a transfer unit. An NMI then lets a channel that is mid-unit finish that unit before its permit drops. Clearing the run enable stops every channel at once.

Top module: `dmg_group_ctrl`

## Requirements
- R1: After reset, the control word reads 0, every permit is 0 and every stop pulse is 0.
- R2: The control word uses bit 0 for the run enable, bit 1 for the NMI flag and bit 2 for the fault flag, and its other bits read 0. Outside an NMI drain, permit[i] is 1 exactly when the run enable is 1, chan_en[i] is 1, chan_end[i] is 0 and both flags are 0.
- R3: A pulse on nmi_in sets the NMI flag from the next cycle on. This also happens when the run enable is 0 and no channel is enabled.
- R4: A write clears a flag only when its bit in wdata is 0 and a read has returned that flag as 1 since the previous write. Any write consumes the read. A write of 0 with no such read leaves the flag at 1.
- R5: A write of 1 to a flag bit neither sets nor clears that flag.
- R6: If a flag-setting event and a valid clearing write fall in the same cycle, the flag is 1 afterwards.
- R7: While the NMI flag is 1, a channel loses its permit once it is not mid-unit. If the channel had its permit and unit_busy[i] was 1 in the cycle the NMI pulse arrived, the permit stays 1 until the cycle after unit_busy[i] goes to 0. A channel that is idle loses its permit in the first cycle the flag reads 1.
- R8: A write of 0 to the run enable removes every permit in the next cycle, whether or not a channel is mid-unit.
- R9: A pulse on any bit of addr_fault sets the fault flag from the next cycle on. While it is 1, all permits are 0. It clears under the same rule as R4.
- R10: stop[i] is 1 for exactly one cycle when permit[i] falls from 1 to 0 while chan_en[i] is 1 and chan_end[i] is 0. It is 0 otherwise.
- R11: A write of 1 to the run enable grants permit, from the next cycle, to every channel that meets R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_rd | input | 1 | Read strobe for the control word |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | CTRL_W | Write data |
| reg_rdata | output | CTRL_W | Current control word |
| nmi_in | input | 1 | NMI event pulse |
| addr_fault | input | NCH | Per-channel address fault pulses |
| chan_en | input | NCH | Per-channel enable |
| chan_end | input | NCH | Per-channel transfer-finished indication |
| unit_busy | input | NCH | Channel is inside a transfer unit |
| permit | output | NCH | Channel may transfer |
| stop | output | NCH | Pulse when a live channel loses its permit |

## Verification
Directed sequences first walk the flag handshake. The cases are a clearing write with no read before it, a write of 1 after a read, a clear that meets a new NMI in the same cycle, and a proper read-then-clear. Together they separate the read-tracking rule from a plain write-to-clear. NMI stops are tried on one channel that is mid-unit while the others are idle, which shows the unit drain apart from an immediate stop. A run-enable clear with every channel busy then shows that this stop ignores unit boundaries. A long random phase follows, mixing register traffic, rare NMI and fault pulses, and changing enable, finish and busy inputs. Every cycle is compared against a cycle model computed in the bench.

// File: rtl/dmg_pkg.sv
package dmg_pkg;
   localparam int EN_BIT     = 0;
   localparam int NMI_BIT    = 1;
   localparam int FAULT_BIT  = 2;
   localparam int MIN_CTRL_W = 3;
endpackage

// File: rtl/dmg_sticky_flag.sv
module dmg_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic rd_i,
   input  logic wr_i,
   input  logic wbit_i,
   output logic flag_o
);
   logic flag_q;
   logic arm_q;
   logic clr;

   // clearing write needs a read that saw 1 since the previous write
   assign clr = wr_i & arm_q & ~wbit_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         arm_q  <= 1'b0;
      end else begin
         flag_q <= set_i | (flag_q & ~clr);
         if (wr_i)
            arm_q <= 1'b0;
         else if (rd_i && flag_q)
            arm_q <= 1'b1;
      end
   end

   assign flag_o = flag_q;

   // R6: set wins over a coincident clear
   p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_q);
   // R5: a written 1 changes nothing
   p_write_one_inert_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && wbit_i && !set_i) |=> (flag_q == $past(flag_q)));
   // R4: no clear without a preceding read of 1
   p_unarmed_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && wr_i && !arm_q) |=> flag_q);
endmodule

// File: rtl/dmg_chan_gate.sv
module dmg_chan_gate #(
   parameter bit UNIT_DRAIN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic nmi_i,
   input  logic fault_i,
   input  logic de_i,
   input  logic end_i,
   input  logic busy_i,
   output logic permit_o,
   output logic stop_o
);
   logic base_ok;
   logic prev_q;

   assign base_ok = run_i & de_i & ~end_i & ~fault_i;

   if (UNIT_DRAIN) begin : g_drain
      logic drain_q;
      // tracks "mid-unit while allowed"; frozen once the NMI flag is up
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) drain_q <= 1'b0;
         else        drain_q <= base_ok & busy_i & (drain_q | ~nmi_i);
      end
      assign permit_o = base_ok & (~nmi_i | drain_q);

      // R7: a permitted channel mid-unit keeps going unless a hard cause hits
      p_unit_finishes_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (permit_o && busy_i) |=> (permit_o || !run_i || !de_i || end_i || fault_i));
   end else begin : g_abrupt
      assign permit_o = base_ok & ~nmi_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= permit_o;
   end

   assign stop_o = prev_q & ~permit_o & de_i & ~end_i;

   // R7: an idle channel under NMI is blocked next cycle
   p_nmi_idle_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi_i && !busy_i) |=> (!permit_o || !nmi_i));
   // R10: stop is a single-cycle pulse
   p_stop_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      stop_o |=> !stop_o);
endmodule

// File: rtl/dmg_group_ctrl.sv
module dmg_group_ctrl #(
   parameter int NCH        = 6,
   parameter int CTRL_W     = 8,
   parameter bit UNIT_DRAIN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_rd,
   input  logic              reg_wr,
   input  logic [CTRL_W-1:0] reg_wdata,
   output logic [CTRL_W-1:0] reg_rdata,
   input  logic              nmi_in,
   input  logic [NCH-1:0]    addr_fault,
   input  logic [NCH-1:0]    chan_en,
   input  logic [NCH-1:0]    chan_end,
   input  logic [NCH-1:0]    unit_busy,
   output logic [NCH-1:0]    permit,
   output logic [NCH-1:0]    stop
);
   import dmg_pkg::*;

   localparam int PAD_W = CTRL_W - MIN_CTRL_W;

   if (CTRL_W < MIN_CTRL_W) begin : g_bad_width
      $error("CTRL_W must hold the three control bits");
   end
   if (NCH < 1) begin : g_bad_nch
      $error("NCH must be at least 1");
   end

   logic run_q;
   logic nmi_flag;
   logic fault_flag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      run_q <= 1'b0;
      else if (reg_wr) run_q <= reg_wdata[EN_BIT];
   end

   dmg_sticky_flag u_nmi_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (nmi_in),
      .rd_i   (reg_rd),
      .wr_i   (reg_wr),
      .wbit_i (reg_wdata[NMI_BIT]),
      .flag_o (nmi_flag)
   );

   dmg_sticky_flag u_fault_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (|addr_fault),
      .rd_i   (reg_rd),
      .wr_i   (reg_wr),
      .wbit_i (reg_wdata[FAULT_BIT]),
      .flag_o (fault_flag)
   );

   if (PAD_W > 0) begin : g_pad
      assign reg_rdata = {{PAD_W{1'b0}}, fault_flag, nmi_flag, run_q};
   end else begin : g_nopad
      assign reg_rdata = {fault_flag, nmi_flag, run_q};
   end

   for (genvar i = 0; i < NCH; i++) begin : g_chan
      dmg_chan_gate #(.UNIT_DRAIN(UNIT_DRAIN)) u_gate (
         .clk      (clk),
         .rst_n    (rst_n),
         .run_i    (run_q),
         .nmi_i    (nmi_flag),
         .fault_i  (fault_flag),
         .de_i     (chan_en[i]),
         .end_i    (chan_end[i]),
         .busy_i   (unit_busy[i]),
         .permit_o (permit[i]),
         .stop_o   (stop[i])
      );
   end

   // R8: clearing the run enable empties all permits next cycle
   p_run_clear_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !reg_wdata[EN_BIT]) |=> (permit == '0));
   // R9: any fault pulse blocks the whole group next cycle
   p_fault_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (|addr_fault) |=> (permit == '0));
   // R3: NMI pulse sets the flag regardless of activity
   p_nmi_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_in |=> reg_rdata[NMI_BIT]);
endmodule

// File: tb/test_dmg_group_ctrl.sv
`timescale 1ns/1ps
module test_dmg_group_ctrl;
   localparam int NCH = 6;
   localparam int CW  = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rd = 0, wr = 0, nmi = 0;
   logic [CW-1:0] wdata = '0;
   logic [NCH-1:0] aerr = '0, de = '0, te = '0, busy = '0;
   logic [CW-1:0] rdata;
   logic [NCH-1:0] permit, stop;

   int n_run = 0, n_fail = 0;
   bit done = 0;

   // bench model state
   bit m_en, m_nmi, m_ae, m_arm_n, m_arm_a;
   bit [NCH-1:0] m_drain, m_prev;

   always #2.5 clk = ~clk;

   dmg_group_ctrl #(.NCH(NCH), .CTRL_W(CW)) i_dmg_group_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_rd(rd), .reg_wr(wr), .reg_wdata(wdata),
      .reg_rdata(rdata), .nmi_in(nmi), .addr_fault(aerr), .chan_en(de),
      .chan_end(te), .unit_busy(busy), .permit(permit), .stop(stop)
   );

   function automatic bit [NCH-1:0] f_base();
      return (m_en && !m_ae) ? (de & ~te) : '0;
   endfunction

   function automatic bit [NCH-1:0] f_permit();
      return f_base() & (m_nmi ? m_drain : {NCH{1'b1}});
   endfunction

   function automatic bit [NCH-1:0] f_stop();
      return m_prev & ~f_permit() & de & ~te;
   endfunction

   function automatic bit [CW-1:0] f_rdata();
      bit [CW-1:0] v = '0;
      v[0] = m_en; v[1] = m_nmi; v[2] = m_ae;
      return v;
   endfunction

   task automatic chk(string tag, string what, logic [CW-1:0] act, logic [CW-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_en = 0; m_nmi = 0; m_ae = 0; m_arm_n = 0; m_arm_a = 0;
      m_drain = '0; m_prev = '0;
   endtask

   // called at a falling edge with inputs already set
   task automatic step(string tag);
      bit [NCH-1:0] p;
      bit clr_n, clr_a;
      #1;
      chk(tag, "rdata", rdata, f_rdata());
      chk(tag, "permit", CW'(permit), CW'(f_permit()));
      chk(tag, "stop", CW'(stop), CW'(f_stop()));
      @(posedge clk);
      p = f_permit();
      clr_n = wr && m_arm_n && !wdata[1];
      clr_a = wr && m_arm_a && !wdata[2];
      m_drain = f_base() & busy & (m_drain | (m_nmi ? '0 : {NCH{1'b1}}));
      m_prev = p;
      m_arm_n = wr ? 0 : ((rd && m_nmi) ? 1 : m_arm_n);
      m_arm_a = wr ? 0 : ((rd && m_ae) ? 1 : m_arm_a);
      m_nmi = nmi || (m_nmi && !clr_n);
      m_ae = (|aerr) || (m_ae && !clr_a);
      if (wr) m_en = wdata[0];
      @(negedge clk);
   endtask

   task automatic idle_in();
      rd = 0; wr = 0; nmi = 0; aerr = '0;
   endtask

   task automatic do_write(string tag, logic [CW-1:0] v);
      idle_in(); wr = 1; wdata = v; step(tag); wr = 0;
   endtask

   task automatic do_read(string tag);
      idle_in(); rd = 1; step(tag); rd = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1d5a_7e03));
      model_reset();
      repeat (3) @(negedge clk);
      // R1: reset values
      #1;
      chk("R1", "rdata", rdata, '0);
      chk("R1", "permit", CW'(permit), '0);
      chk("R1", "stop", CW'(stop), '0);
      @(negedge clk);
      rst_n = 1;
      step("R1");

      // R11: run enable grants permits
      de = '1;
      do_write("R11", 8'h01);
      step("R11");
      // R2: finish and per-channel enable gate individually
      te = 6'b000100; de = 6'b101111;
      step("R2");
      te = '0; de = '1;
      step("R2");

      // R7: channel 0 mid-unit drains, others stop at once
      busy = 6'b000001;
      step("R7");
      nmi = 1; step("R7"); nmi = 0;
      step("R7"); step("R7");
      busy = '0;
      step("R7"); step("R7");

      // R4: write 0 without a prior read keeps the flag
      do_write("R4", 8'h01);
      step("R4");
      do_read("R4");
      do_write("R4", 8'h01);
      step("R4");

      // R3: NMI while idle and nothing enabled
      do_write("R3", 8'h00);
      de = '0;
      nmi = 1; step("R3"); nmi = 0;
      step("R3");

      // R6: set coincident with clearing write
      do_read("R6");
      idle_in(); wr = 1; wdata = 8'h00; nmi = 1; step("R6");
      idle_in(); step("R6");

      // R5: write 1 after read keeps flag, and consumes the read
      do_read("R5");
      do_write("R5", 8'h02);
      do_write("R5", 8'h00);
      step("R5");
      do_read("R5");
      do_write("R5", 8'h00);
      step("R5");
      // R5: write 1 to clear flag does not set it
      do_write("R5", 8'h06);
      step("R5");

      // R8 and R10: run clear with all busy
      de = '1; busy = '1;
      do_write("R8", 8'h01);
      step("R8");
      do_write("R8", 8'h00);
      step("R10"); step("R10");

      // R9: fault flag blocks and clears by handshake
      do_write("R9", 8'h01);
      busy = '0;
      step("R9");
      aerr = 6'b010000; step("R9"); aerr = '0;
      step("R9");
      do_write("R9", 8'h01);
      step("R9");
      do_read("R9");
      do_write("R9", 8'h01);
      step("R9");

      // R2: random mix
      for (int k = 0; k < 3000; k++) begin
         rd = ($urandom % 4) == 0;
         wr = ($urandom % 6) == 0;
         wdata = CW'($urandom);
         wdata[0] = ($urandom % 8) != 0;
         nmi = ($urandom % 40) == 0;
         aerr = (($urandom % 80) == 0) ? NCH'(1 << ($urandom % NCH)) : '0;
         if (($urandom % 10) == 0) de = NCH'($urandom);
         te = (($urandom % 5) == 0) ? NCH'($urandom) : '0;
         busy = NCH'($urandom);
         step("R2");
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule